// File: doc/BRIEF.md
# Burst Column/Row Address Sequencer

This block produces the address sequence of one memory burst on a double-data-rate memory interface. A burst is loaded with a start row, a start column and a burst configuration. The block then presents one address per beat, and the consumer moves it to the next beat with an advance strobe. A beat carries two transfers, so every presented column is even and stands for the pair (col, col+1). The sequence follows one of three patterns. Plain wrap stays inside an aligned window. Hybrid wrap runs once around the window and then climbs linearly through the page. A linear command walks the whole page and, for reads with crossing enabled, can roll over into the following row.

A burst runs until `stop` is pulsed or a new `start` replaces it. If the start column is odd, the block rejects it with an error pulse and presents no beats. The power-on configuration that the surrounding logic normally supplies is hybrid wrap with a 32-entry window (`burst_cfg` = 3'b101).

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `beat_valid`, `row_cross` and `align_err` are all low.
- R2: A `start` with an even start column makes `beat_valid` high one clock later, with `beat_row` equal to the start row and `beat_col` equal to the start column. Every presented column is even.
- R3: A `start` whose column has bit 0 set raises `align_err` for exactly one clock, one clock later, and leaves `beat_valid` low.
- R4: When `linear_cmd` is 0 and `burst_cfg[2]` is 0 (plain wrap), `burst_cfg[1:0]` of 00, 01 or 10 selects an aligned window of 16, 32 or 64 columns. Each advance adds 2 to the column, and the column wraps to the window base on reaching the window end.
- R5: `burst_cfg[1:0]` = 11 selects the full page. The page is 2048 columns when `wide_mode` is 0 and 1024 columns when `wide_mode` is 1. The column wraps to 0 after the last pair of the page.
- R6: When `burst_cfg[2]` is 1 (hybrid) and `burst_cfg[1:0]` is not 11, the column first covers the aligned window once, starting at the start column. It then continues from the next window base, incrementing by 2 up to the page end, wraps to 0, and keeps incrementing without further window wraps. When `burst_cfg[1:0]` is 11, hybrid behaves as the full-page wrap of R5.
- R7: When `linear_cmd` is 1, `burst_cfg` is ignored and the sequence is the full-page wrap of R5.
- R8: When `linear_cmd`, `read_cmd` and `cross_en` are all 1 at start, an advance past the last pair of the page gives column 0 of row+1 (modulo 2^14). `row_cross` is high for exactly that beat.
- R9: In every other case the row never changes during a burst, and `row_cross` stays low.
- R10: While `beat_valid` is high and neither `advance`, `stop` nor `start` is asserted, the presented address holds. A `stop` pulse drops `beat_valid` one clock later.
- R11: When `wide_mode` is 1, column bit 10 of the start address is ignored and the presented column never has bit 10 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load a new burst (has priority over stop and advance) |
| start_row | input | 14 | Start row |
| start_col | input | 11 | Start column, must be even |
| wide_mode | input | 1 | 1: 16-bit mode (1024-column page), 0: 8-bit mode (2048-column page) |
| burst_cfg | input | 3 | Bit 2 hybrid, bits 1:0 window 16/32/64/page |
| linear_cmd | input | 1 | Linear command: full-page wrap, configuration ignored |
| read_cmd | input | 1 | The burst is a read |
| cross_en | input | 1 | Allow linear reads to roll into the next row |
| advance | input | 1 | Consume the current beat |
| stop | input | 1 | End the burst |
| beat_valid | output | 1 | The presented address is valid |
| beat_row | output | 14 | Row of the current beat |
| beat_col | output | 11 | Even column of the current beat pair |
| row_cross | output | 1 | The current beat's row is the incremented one |
| align_err | output | 1 | One-clock pulse for an odd start column |

## Verification
The assertions check on every cycle that presented columns stay even and, in 16-bit mode, below 1024. They also check that an idle beat holds its address, that the row changes only together with a crossing pulse, that a crossing beat sits at column 0 and carries the previous row plus one, and that the alignment error is a single-clock pulse with no valid beat. The actual order of columns cannot be shown by a property of this kind, so only the bench's scenarios cover it. These scenarios cover the window wrap point, the end of the hybrid first pass, the page wrap in both widths, the rollover from row 16383 to row 0, and the suppression of crossing for writes and non-linear bursts.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int ROW_W_DEF   = 14;
  localparam int COL_W_DEF   = 11;
  localparam int MIN_WIN_LOG = 4;

  typedef struct packed {
    logic       wide;
    logic       hybrid;
    logic [1:0] win_sel;
    logic       linear;
    logic       cross_ok;
  } burst_cfg_t;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_pkg::*;
#(
  parameter int COL_W   = COL_W_DEF,
  parameter int MIN_LOG = MIN_WIN_LOG
) (
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] page_mask,
  output logic [COL_W-1:0] win_mask,
  output logic             hybrid_eff
);
  localparam logic [COL_W-1:0] NARROW_PAGE = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] WIDE_PAGE   = {1'b0, {(COL_W-1){1'b1}}};

  always_comb begin
    page_mask = cfg.wide ? WIDE_PAGE : NARROW_PAGE;
    if (cfg.linear) begin
      win_mask   = page_mask;
      hybrid_eff = 1'b0;
    end else begin
      case (cfg.win_sel)
        2'd0:    win_mask = COL_W'((1 << MIN_LOG) - 1);
        2'd1:    win_mask = COL_W'((1 << (MIN_LOG + 1)) - 1);
        2'd2:    win_mask = COL_W'((1 << (MIN_LOG + 2)) - 1);
        default: win_mask = page_mask;
      endcase
      hybrid_eff = cfg.hybrid && (cfg.win_sel != 2'd3);
    end
  end
endmodule

// File: rtl/burst_col_step.sv
module burst_col_step #(
  parameter int COL_W = 11
) (
  input  logic [COL_W-1:0] col,
  input  logic [COL_W-1:0] first_col,
  input  logic             first_pass,
  input  logic             hybrid,
  input  logic [COL_W-1:0] page_mask,
  input  logic [COL_W-1:0] win_mask,
  output logic [COL_W-1:0] nxt_col,
  output logic             nxt_first,
  output logic             page_end
);
  logic [COL_W-1:0] inc;
  logic [COL_W-1:0] win_base;
  logic [COL_W-1:0] win_nxt;
  logic [COL_W-1:0] page_nxt;
  logic [COL_W-1:0] next_win;
  logic             last_pair;

  always_comb begin
    inc       = col + COL_W'(2);
    win_base  = col & ~win_mask;
    win_nxt   = win_base | (inc & win_mask);
    page_nxt  = inc & page_mask;
    next_win  = (win_base + win_mask + COL_W'(1)) & page_mask;
    last_pair = (col | COL_W'(1)) == page_mask;

    nxt_col   = win_nxt;
    nxt_first = first_pass;
    page_end  = 1'b0;
    if (hybrid && first_pass) begin
      if (win_nxt == first_col) begin
        nxt_col   = next_win;
        nxt_first = 1'b0;
      end
    end else if (hybrid) begin
      nxt_col  = page_nxt;
      page_end = last_pair;
    end else begin
      page_end = last_pair && (win_mask == page_mask);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ROW_W = ROW_W_DEF,
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic [COL_W-1:0] start_col,
  input  logic             wide_mode,
  input  logic [2:0]       burst_cfg,
  input  logic             linear_cmd,
  input  logic             read_cmd,
  input  logic             cross_en,
  input  logic             advance,
  input  logic             stop,
  output logic             beat_valid,
  output logic [ROW_W-1:0] beat_row,
  output logic [COL_W-1:0] beat_col,
  output logic             row_cross,
  output logic             align_err
);
  logic             rst_n_s;
  burst_cfg_t       cfg_q, cfg_d;
  logic [COL_W-1:0] first_q, first_d;
  logic             pass_q, pass_d;
  logic             valid_d, rx_d, err_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic             upd_en;

  logic [COL_W-1:0] page_mask, win_mask;
  logic             hybrid_eff;
  logic [COL_W-1:0] step_col;
  logic             step_first, step_end;
  logic [COL_W-1:0] load_col;

  burst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .cfg        (cfg_q),
    .page_mask  (page_mask),
    .win_mask   (win_mask),
    .hybrid_eff (hybrid_eff)
  );

  burst_col_step #(.COL_W(COL_W)) u_step (
    .col        (beat_col),
    .first_col  (first_q),
    .first_pass (pass_q),
    .hybrid     (hybrid_eff),
    .page_mask  (page_mask),
    .win_mask   (win_mask),
    .nxt_col    (step_col),
    .nxt_first  (step_first),
    .page_end   (step_end)
  );

  assign load_col = wide_mode ? {1'b0, start_col[COL_W-2:0]} : start_col;
  assign upd_en   = start | stop | (beat_valid & advance) | align_err;

  always_comb begin
    cfg_d   = cfg_q;
    first_d = first_q;
    pass_d  = pass_q;
    valid_d = beat_valid;
    row_d   = beat_row;
    col_d   = beat_col;
    rx_d    = row_cross;
    err_d   = 1'b0;
    if (start) begin
      cfg_d.wide     = wide_mode;
      cfg_d.hybrid   = burst_cfg[2];
      cfg_d.win_sel  = burst_cfg[1:0];
      cfg_d.linear   = linear_cmd;
      cfg_d.cross_ok = linear_cmd & read_cmd & cross_en;
      first_d        = load_col;
      pass_d         = 1'b1;
      row_d          = start_row;
      col_d          = load_col;
      rx_d           = 1'b0;
      err_d          = start_col[0];
      valid_d        = ~start_col[0];
    end else if (stop) begin
      valid_d = 1'b0;
      rx_d    = 1'b0;
    end else if (beat_valid && advance) begin
      col_d  = step_col;
      pass_d = step_first;
      if (step_end && cfg_q.cross_ok) begin
        row_d = beat_row + ROW_W'(1);
        rx_d  = 1'b1;
      end else begin
        rx_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cfg_q      <= '0;
      first_q    <= '0;
      pass_q     <= 1'b0;
      beat_valid <= 1'b0;
      beat_row   <= '0;
      beat_col   <= '0;
      row_cross  <= 1'b0;
      align_err  <= 1'b0;
    end else if (upd_en) begin
      cfg_q      <= cfg_d;
      first_q    <= first_d;
      pass_q     <= pass_d;
      beat_valid <= valid_d;
      beat_row   <= row_d;
      beat_col   <= col_d;
      row_cross  <= rx_d;
      align_err  <= err_d;
    end
  end
endmodule

module burst_addr_chk #(
  parameter int ROW_W = 14,
  parameter int COL_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             advance,
  input logic             stop,
  input logic             wide_mode,
  input logic             beat_valid,
  input logic [ROW_W-1:0] beat_row,
  input logic [COL_W-1:0] beat_col,
  input logic             row_cross,
  input logic             align_err
);
  logic wide_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wide_seen <= 1'b0;
    else if (start) wide_seen <= wide_mode;
  end

  assert_even_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !beat_col[0]);

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !start) |=> !align_err);

  assert_err_no_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !beat_valid);

  assert_cross_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_cross |-> (beat_col == '0));

  assert_cross_row_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && advance && !start && !stop) |=>
      (!row_cross || beat_row == $past(beat_row) + ROW_W'(1)));

  assert_row_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !start) |=> (row_cross || beat_row == $past(beat_row)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !advance && !start && !stop) |=>
      ($stable(beat_col) && $stable(beat_row) && beat_valid));

  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !beat_valid);

  assert_wide_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && wide_seen && !$rose(beat_valid)) |-> !beat_col[COL_W-1]);
endmodule

bind burst_addr_gen burst_addr_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .advance    (advance),
  .stop       (stop),
  .wide_mode  (wide_mode),
  .beat_valid (beat_valid),
  .beat_row   (beat_row),
  .beat_col   (beat_col),
  .row_cross  (row_cross),
  .align_err  (align_err)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] start_row = '0;
  logic [10:0] start_col = '0;
  logic        wide_mode = 1'b0;
  logic [2:0]  burst_cfg = 3'b101;
  logic        linear_cmd = 1'b0;
  logic        read_cmd = 1'b0;
  logic        cross_en = 1'b0;
  logic        advance = 1'b0;
  logic        stop = 1'b0;
  logic        beat_valid;
  logic [13:0] beat_row;
  logic [10:0] beat_col;
  logic        row_cross;
  logic        align_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
    .start_col(start_col), .wide_mode(wide_mode), .burst_cfg(burst_cfg),
    .linear_cmd(linear_cmd), .read_cmd(read_cmd), .cross_en(cross_en),
    .advance(advance), .stop(stop), .beat_valid(beat_valid),
    .beat_row(beat_row), .beat_col(beat_col), .row_cross(row_cross),
    .align_err(align_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected beat k of a burst, computed by index from the requirements.
  function automatic void model(input int srow, input int scol, input bit wd,
      input int cfg, input bit lin, input bit rd, input bit en, input int k,
      output int erow, output int ecol, output bit ex);
    int page, w, col0, base, off, bl, pos;
    bit hyb;
    page = wd ? 1024 : 2048;
    col0 = scol % page;
    bl = cfg % 4;
    if (lin) begin w = page; hyb = 0; end
    else begin w = (bl == 3) ? page : (16 << bl); hyb = (cfg >= 4) && (bl != 3); end
    base = col0 - (col0 % w);
    off = col0 % w;
    erow = srow;
    ex = 0;
    if (lin && rd && en) begin
      pos = col0 + 2 * k;
      ecol = pos % page;
      erow = (srow + pos / page) % 16384;
      ex = (k > 0) && (ecol == 0);
    end else if (hyb && k >= w / 2) begin
      ecol = (base + w + 2 * (k - w / 2)) % page;
    end else begin
      ecol = base + (off + 2 * k) % w;
    end
  endfunction

  task automatic run_burst(input string req, input int srow, input int scol,
      input bit wd, input int cfg, input bit lin, input bit rd, input bit en,
      input int nbeats);
    int er, ec;
    bit ex;
    start_row = 14'(srow); start_col = 11'(scol); wide_mode = wd;
    burst_cfg = 3'(cfg); linear_cmd = lin; read_cmd = rd; cross_en = en;
    start = 1'b1; advance = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < nbeats; k++) begin
      if (k > 0) begin advance = 1'b1; @(negedge clk); end
      model(srow, scol, wd, cfg, lin, rd, en, k, er, ec, ex);
      check(beat_valid === 1'b1, req, "valid", int'(beat_valid), 1);
      check(beat_col === 11'(ec), req, "col", int'(beat_col), ec);
      check(beat_row === 14'(er), req, "row", int'(beat_row), er);
      check(row_cross === ex, req, "row_cross", int'(row_cross), int'(ex));
    end
    advance = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(beat_valid === 1'b0, "R10", "valid after stop", int'(beat_valid), 0);
  endtask

  initial begin
    int starts [4] = '{0, 2, 38, 2030};
    int hold_col;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(beat_valid === 1'b0, "R1", "valid in reset", int'(beat_valid), 0);
    check(row_cross === 1'b0, "R1", "row_cross in reset", int'(row_cross), 0);
    check(align_err === 1'b0, "R1", "align_err in reset", int'(align_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(beat_valid === 1'b0, "R1", "valid after reset", int'(beat_valid), 0);

    // R2 R4 R5 R6 R7: sweep over widths, configs, command kinds and starts
    for (int wd = 0; wd < 2; wd++)
      for (int cfg = 0; cfg < 8; cfg++)
        for (int lin = 0; lin < 2; lin++)
          for (int s = 0; s < 4; s++)
            run_burst(lin ? "R7" : (cfg >= 4 ? "R6" : "R4"), 100 + s,
                      starts[s], wd[0], cfg, lin[0], 1'b1, 1'b0, 80);

    // R5: full page wraps in both widths
    run_burst("R5", 7, 6, 1'b0, 3, 1'b0, 1'b0, 1'b0, 1030);
    run_burst("R5", 7, 1000, 1'b1, 7, 1'b0, 1'b0, 1'b0, 520);
    // R6: hybrid climbs through page end and wraps to 0
    run_burst("R6", 9, 1000, 1'b1, 4, 1'b0, 1'b0, 1'b0, 600);
    run_burst("R6", 9, 2032, 1'b0, 6, 1'b0, 1'b0, 1'b0, 70);

    // R8: linear read with crossing enabled rolls the row
    run_burst("R8", 5, 2040, 1'b0, 1, 1'b1, 1'b1, 1'b1, 12);
    run_burst("R8", 16383, 2046, 1'b0, 5, 1'b1, 1'b1, 1'b1, 6);
    run_burst("R8", 300, 1018, 1'b1, 0, 1'b1, 1'b1, 1'b1, 8);
    // R9: write, non-linear, or disabled: row stays
    run_burst("R9", 5, 2040, 1'b0, 3, 1'b1, 1'b0, 1'b1, 12);
    run_burst("R9", 5, 2040, 1'b0, 3, 1'b0, 1'b1, 1'b1, 12);
    run_burst("R9", 5, 2040, 1'b0, 3, 1'b1, 1'b1, 1'b0, 12);

    // R11: bit 10 of the start column ignored in 16-bit mode
    run_burst("R11", 1, 11'h402, 1'b1, 3, 1'b0, 1'b0, 1'b0, 3);

    // R10: address held without advance
    start_col = 11'd20; start_row = 14'd3; wide_mode = 1'b0;
    burst_cfg = 3'b000; linear_cmd = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    hold_col = int'(beat_col);
    check(hold_col == 22, "R10", "col before hold", hold_col, 22);
    repeat (3) @(negedge clk);
    check(beat_col === 11'd22, "R10", "col held", int'(beat_col), 22);
    check(beat_valid === 1'b1, "R10", "valid held", int'(beat_valid), 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(beat_valid === 1'b0, "R10", "valid after stop", int'(beat_valid), 0);

    // R3: odd start column
    start_col = 11'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(align_err === 1'b1, "R3", "align_err raised", int'(align_err), 1);
    check(beat_valid === 1'b0, "R3", "no beat on error", int'(beat_valid), 0);
    @(negedge clk);
    check(align_err === 1'b0, "R3", "align_err one clock", int'(align_err), 0);
    check(beat_valid === 1'b0, "R3", "still no beat", int'(beat_valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule